// File: doc/BRIEF.md
# Five-Level Noise-Shaping Modulator

This block turns one channel of oversampled audio into a stream of five-level codes. It accepts 18-bit two's-complement words that arrive at eight times the sample rate. It runs a third-order noise-shaping loop clocked by a modulator tick enable. Each tick it emits a code from 0 to 4. Code 2 is the midpoint, and codes 0 and 4 are the outer levels. The downstream analog stage turns the code stream into a voltage, and averaging it recovers the input.

The loop holds three delaying integrators in cascade. The first integrates the input minus the quantizer feedback, and each later one integrates the stage before it. Their outputs are summed with the weights 1.5, 0.75 and 0.125, which are built from shifts, and added to the input before quantization. The noise transfer function then has three zeros at DC and three poles at z = 0.5, while the signal passes with unity gain. A mode input picks how many ticks one input word covers: 6 ticks for a 384fS system clock, 8 ticks for 256fS. A captured word goes live only on the first tick of a frame. A force input parks the output at the midpoint and clears the loop.

Top module: `dsm5_modulator`

## Requirements
- R1: After synchronous reset the code is 2, the integrators are zero and no input word is live, so ticks before any word is loaded keep producing code 2.
- R2: The code is always in 0..4 and encodes the level L = code - 2. The fed-back value is L * 2^16. With a cleared loop, the first tick maps input x to L = floor((x + 32768) / 65536), clamped to -2..+2.
- R3: The code register changes only on a cycle where the tick is high, or where reset or force is high. Loading a new word without a tick leaves the code unchanged.
- R4: While force is high, the code is 2 from the next cycle on, whatever the input and ticks are. Force clears the integrators and restarts the frame. A loaded word survives force and is used on the first tick after release.
- R5: A frame is 6 ticks when mode_384 is 1 and 8 ticks when it is 0, counted from reset or force. A word loaded by smp_en becomes live on the first tick of the next frame, and earlier ticks still use the previous word.
- R6: With a zero input and a cleared loop, every code is exactly 2.
- R7: For a constant input x with |x| <= 65536, the mean of L * 2^16 over 512 ticks, taken after 64 warm-up ticks, is within 2621 (1% of the 2^18 input span) of x.
- R8: Each integrator saturates at its signed limits instead of wrapping, and an integrator never moves against the sign of its input. Under full-scale DC of either sign the code stays in 0..4. After force and a zero input, codes return to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_384 | input | 1 | 1: 6 ticks per input word; 0: 8 ticks per input word |
| mod_tick | input | 1 | Modulator tick enable, one output code per high cycle |
| force_mid | input | 1 | Holds output at code 2 and clears loop state |
| smp_en | input | 1 | Captures smp_in as the next input word |
| smp_in | input | 18 | Two's-complement input word |
| dsm_code | output | 3 | Quantizer code 0..4, midpoint 2 |

## Verification
The quantizer thresholds are hard to reach from the ports, because in normal operation the integrator sum hides the input. The bench clears the loop with a force pulse before every threshold point, so the first tick quantizes the loaded word exactly. It then walks words on both sides of each boundary. Integrator saturation needs long runs of full-scale DC of both signs. After these runs, a force pulse and a zero input show that the loop recovers.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;

    localparam int DEF_IN_W      = 18;
    localparam int DEF_GUARD_W   = 8;
    localparam int DEF_TICKS_384 = 6;
    localparam int DEF_TICKS_256 = 8;
    localparam int NUM_INTEG     = 3;

    typedef enum logic [2:0] {
        CODE_NEG2 = 3'd0,
        CODE_NEG1 = 3'd1,
        CODE_MID  = 3'd2,
        CODE_POS1 = 3'd3,
        CODE_POS2 = 3'd4
    } dsm_code_e;

    typedef struct packed {
        dsm_code_e         code;
        logic signed [2:0] level;
    } quant_t;

    function automatic dsm_code_e code_of_level(input logic signed [2:0] lvl);
        logic [2:0] raw;
        raw = lvl + 3'd2;
        return dsm_code_e'(raw);
    endfunction

endpackage

// File: rtl/dsm5_frame_ctl.sv
module dsm5_frame_ctl #(
    parameter int IN_W      = 18,
    parameter int TICKS_384 = 6,
    parameter int TICKS_256 = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_384,
    input  logic                   mod_tick,
    input  logic                   force_mid,
    input  logic                   smp_en,
    input  logic signed [IN_W-1:0] smp_in,
    output logic signed [IN_W-1:0] x_cur
);

    localparam int TICKS_MAX = (TICKS_384 > TICKS_256) ? TICKS_384 : TICKS_256;
    localparam int PH_W      = $clog2(TICKS_MAX + 1);

    logic [PH_W-1:0]        phase_q;
    logic [PH_W-1:0]        last_phase;
    logic signed [IN_W-1:0] stage_q;
    logic signed [IN_W-1:0] live_q;
    logic                   pend_q;
    logic                   frame_start;
    logic                   take;

    assign last_phase  = mode_384 ? PH_W'(TICKS_384 - 1) : PH_W'(TICKS_256 - 1);
    assign frame_start = mod_tick && !force_mid && (phase_q == '0);
    assign take        = frame_start && pend_q;
    assign x_cur       = take ? stage_q : live_q;

    always_ff @(posedge clk) begin
        if (rst || force_mid) begin
            phase_q <= '0;
        end else if (mod_tick) begin
            if (phase_q >= last_phase) phase_q <= '0;
            else                       phase_q <= phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (take) live_q <= stage_q;
            if (smp_en) begin
                stage_q <= smp_in;
                pend_q  <= 1'b1;
            end else if (take) begin
                pend_q  <= 1'b0;
            end
        end
    end

    // R5: phase never leaves the longest frame
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
        phase_q < PH_W'(TICKS_MAX));

    // R5: the live word moves only on a frame's first tick
    p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(live_q));

endmodule

// File: rtl/dsm5_integ.sv
module dsm5_integ #(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] acc
);

    localparam logic signed [ACC_W:0] SAT_HI = $signed({2'b00, {(ACC_W-1){1'b1}}});
    localparam logic signed [ACC_W:0] SAT_LO = $signed({2'b11, {(ACC_W-1){1'b0}}});

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   wide_sum;
    logic signed [ACC_W-1:0] acc_nxt;

    assign wide_sum = $signed({acc_q[ACC_W-1], acc_q}) + $signed({din[ACC_W-1], din});

    always_comb begin
        if (wide_sum > SAT_HI)      acc_nxt = {1'b0, {(ACC_W-1){1'b1}}};
        else if (wide_sum < SAT_LO) acc_nxt = {1'b1, {(ACC_W-1){1'b0}}};
        else                        acc_nxt = wide_sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  acc_q <= '0;
        else if (en)     acc_q <= acc_nxt;
    end

    assign acc = acc_q;

    // R8: a non-negative input never lowers the state (no wrap upward)
    p_no_wrap_up_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && din >= 0) |=> acc_q >= $past(acc_q));

    // R8: a negative input never raises the state (no wrap downward)
    p_no_wrap_dn_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && din < 0) |=> acc_q <= $past(acc_q));

endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant
    import dsm5_pkg::*;
#(
    parameter int SUM_W  = 29,
    parameter int ACC_W  = 26,
    parameter int LVL_SH = 16
) (
    input  logic signed [SUM_W-1:0] v,
    output quant_t                  q,
    output logic signed [ACC_W-1:0] fb
);

    localparam logic signed [SUM_W-1:0] HALF   =
        {{(SUM_W-LVL_SH){1'b0}}, 1'b1, {(LVL_SH-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] LV_MAX = SUM_W'(2);
    localparam logic signed [SUM_W-1:0] LV_MIN = -LV_MAX;

    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] steps;
    logic signed [2:0]       lvl;

    assign biased = v + HALF;
    assign steps  = biased >>> LVL_SH;

    always_comb begin
        if (steps > LV_MAX)      lvl = 3'sd2;
        else if (steps < LV_MIN) lvl = -3'sd2;
        else                     lvl = steps[2:0];
    end

    assign q.level = lvl;
    assign q.code  = code_of_level(lvl);
    assign fb      = ACC_W'(lvl) <<< LVL_SH;

endmodule

// File: rtl/dsm5_modulator.sv
module dsm5_modulator
    import dsm5_pkg::*;
#(
    parameter int IN_W      = DEF_IN_W,
    parameter int GUARD_W   = DEF_GUARD_W,
    parameter int TICKS_384 = DEF_TICKS_384,
    parameter int TICKS_256 = DEF_TICKS_256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_384,
    input  logic                   mod_tick,
    input  logic                   force_mid,
    input  logic                   smp_en,
    input  logic signed [IN_W-1:0] smp_in,
    output logic [2:0]             dsm_code
);

    localparam int ACC_W  = IN_W + GUARD_W;
    localparam int SUM_W  = ACC_W + 3;
    localparam int LVL_SH = IN_W - 2;

    logic signed [IN_W-1:0]  x_cur;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] loop_err;
    logic signed [ACC_W-1:0] st_in  [NUM_INTEG];
    logic signed [ACC_W-1:0] st_acc [NUM_INTEG];
    logic signed [SUM_W-1:0] x_e, s1_e, s2_e, s3_e, v_sum;
    quant_t                  qr;
    dsm_code_e               code_q;

    dsm5_frame_ctl #(
        .IN_W(IN_W), .TICKS_384(TICKS_384), .TICKS_256(TICKS_256)
    ) u_frame (
        .clk(clk), .rst(rst), .mode_384(mode_384), .mod_tick(mod_tick),
        .force_mid(force_mid), .smp_en(smp_en), .smp_in(smp_in), .x_cur(x_cur)
    );

    assign loop_err = ACC_W'(x_cur) - fb;

    for (genvar k = 0; k < NUM_INTEG; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign st_in[k] = loop_err;
        end else begin : g_chain
            assign st_in[k] = st_acc[k-1];
        end
        dsm5_integ #(.ACC_W(ACC_W)) u_integ (
            .clk(clk), .rst(rst), .clr(force_mid), .en(mod_tick),
            .din(st_in[k]), .acc(st_acc[k])
        );
    end

    assign x_e  = SUM_W'(x_cur);
    assign s1_e = SUM_W'(st_acc[0]);
    assign s2_e = SUM_W'(st_acc[1]);
    assign s3_e = SUM_W'(st_acc[2]);

    // weights 1.5, 0.75, 0.125 place all three loop poles at z = 0.5
    assign v_sum = x_e + s1_e + (s1_e >>> 1) + (s2_e >>> 1) + (s2_e >>> 2) + (s3_e >>> 3);

    dsm5_quant #(.SUM_W(SUM_W), .ACC_W(ACC_W), .LVL_SH(LVL_SH)) u_quant (
        .v(v_sum), .q(qr), .fb(fb)
    );

    always_ff @(posedge clk) begin
        if (rst || force_mid) code_q <= CODE_MID;
        else if (mod_tick)    code_q <= qr.code;
    end

    assign dsm_code = code_q;

    // R2: the code register never holds a value above the top level
    p_code_range_r2: assert property (@(posedge clk) disable iff (rst)
        dsm_code <= 3'd4);

    // R3: without tick or force the code holds
    p_tick_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (!mod_tick && !force_mid) |=> $stable(dsm_code));

    // R4: force parks the output at the midpoint
    p_force_mid_r4: assert property (@(posedge clk) disable iff (rst)
        force_mid |=> dsm_code == 3'd2);

    // R6: a cleared loop with zero input quantizes to the midpoint
    p_zero_rest_r6: assert property (@(posedge clk) disable iff (rst)
        (mod_tick && !force_mid && x_cur == '0 && st_acc[0] == '0
         && st_acc[1] == '0 && st_acc[2] == '0) |=> dsm_code == 3'd2);

endmodule

// File: tb/dsm5_modulator_tb.sv
`timescale 1ns/1ps
module dsm5_modulator_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_384 = 1'b1;
    logic              mod_tick = 1'b0;
    logic              force_mid = 1'b0;
    logic              smp_en = 1'b0;
    logic signed [17:0] smp_in = '0;
    logic [2:0]        dsm_code;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dsm5_modulator u_dut (
        .clk(clk), .rst(rst), .mode_384(mode_384), .mod_tick(mod_tick),
        .force_mid(force_mid), .smp_en(smp_en), .smp_in(smp_in), .dsm_code(dsm_code)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst = 1'b1; mode_384 = m; mod_tick = 1'b0; force_mid = 1'b0; smp_en = 1'b0; smp_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); mod_tick = 1'b1;
        @(negedge clk); mod_tick = 1'b0;
    endtask

    task automatic load_word(input int x);
        @(negedge clk); smp_in = x[17:0]; smp_en = 1'b1;
        @(negedge clk); smp_en = 1'b0;
    endtask

    task automatic pulse_force();
        @(negedge clk); force_mid = 1'b1;
        @(negedge clk); force_mid = 1'b0;
    endtask

    function automatic int exp_code(input int x);
        int t, l;
        t = x + 32768;
        if (t >= 0) l = t / 65536;
        else        l = -((-t + 65535) / 65536);
        if (l > 2)  l = 2;
        if (l < -2) l = -2;
        return l + 2;
    endfunction

    initial begin
        #600000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int qx [13];
        int err_cnt;
        longint acc;
        int r;
        bit held;

        // R1: reset state, then idle ticks with nothing loaded
        do_reset(1'b1);
        @(negedge clk);
        check(dsm_code == 3'd2, "R1 reset code", dsm_code, 2);
        err_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            do_tick();
            if (dsm_code != 3'd2) err_cnt++;
        end
        check(err_cnt == 0, "R1 idle ticks after reset", err_cnt, 0);

        // R5: word latency to frame start, both modes
        for (int m = 1; m >= 0; m--) begin
            r = (m == 1) ? 6 : 8;
            do_reset(m[0]);
            repeat (3) do_tick();
            load_word(131071);
            repeat (r - 3) do_tick();
            check(dsm_code == 3'd2, $sformatf("R5 before frame start mode=%0d", m), dsm_code, 2);
            do_tick();
            check(dsm_code == 3'd4, $sformatf("R5 at frame start mode=%0d", m), dsm_code, 4);
        end

        // R3: loading without a tick leaves code unchanged
        held = 1'b1;
        for (int i = 0; i < 4; i++) begin
            load_word(-131072 + i);
            if (dsm_code != 3'd4) held = 1'b0;
        end
        check(held, "R3 no tick no change", dsm_code, 4);

        // R4: force with ticks and a large input keeps code 2
        load_word(131071);
        @(negedge clk); force_mid = 1'b1;
        @(negedge clk);
        check(dsm_code == 3'd2, "R4 force next cycle", dsm_code, 2);
        err_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            do_tick();
            if (dsm_code != 3'd2) err_cnt++;
        end
        check(err_cnt == 0, "R4 force over ticks", err_cnt, 0);
        @(negedge clk); force_mid = 1'b0;
        do_tick();
        check(dsm_code == 3'd4, "R4 restart from cleared loop", dsm_code, 4);

        // R2: quantizer thresholds from a cleared loop
        qx = '{0, 32767, 32768, -32768, -32769, 98303, 98304,
               -98304, -98305, 131071, -131072, 65536, -65536};
        foreach (qx[i]) begin
            load_word(qx[i]);
            pulse_force();
            do_tick();
            check(dsm_code == exp_code(qx[i]), $sformatf("R2 threshold x=%0d", qx[i]),
                  dsm_code, exp_code(qx[i]));
        end

        // R6: zero input keeps every code at 2
        load_word(0);
        pulse_force();
        err_cnt = 0;
        for (int i = 0; i < 512; i++) begin
            do_tick();
            if (dsm_code != 3'd2) err_cnt++;
        end
        check(err_cnt == 0, "R6 zero input codes", err_cnt, 0);

        // R7: DC tracking sweep
        for (int x = -65536; x <= 65536; x += 8192) begin
            load_word(x);
            pulse_force();
            repeat (64) do_tick();
            acc = 0;
            err_cnt = 0;
            for (int i = 0; i < 512; i++) begin
                do_tick();
                if (dsm_code > 3'd4) err_cnt++;
                acc += (longint'(dsm_code) - 2) * 65536;
            end
            check(err_cnt == 0, $sformatf("R2 range during x=%0d", x), err_cnt, 0);
            check((acc - longint'(x) * 512 <= 2621 * 512) && (longint'(x) * 512 - acc <= 2621 * 512),
                  $sformatf("R7 mean x=%0d (sum*512)", x), acc, longint'(x) * 512);
        end

        // R8: full-scale DC of both signs, then recovery
        for (int s = 0; s < 2; s++) begin
            load_word((s == 0) ? 131071 : -131072);
            pulse_force();
            err_cnt = 0;
            for (int i = 0; i < 4000; i++) begin
                do_tick();
                if (dsm_code > 3'd4) err_cnt++;
            end
            check(err_cnt == 0, $sformatf("R8 full-scale range sign=%0d", s), err_cnt, 0);
        end
        load_word(0);
        pulse_force();
        err_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            do_tick();
            if (dsm_code != 3'd2) err_cnt++;
        end
        check(err_cnt == 0, "R8 recovery after full scale", err_cnt, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule